// File: doc/BRIEF.md
# Microstepping Stepper Translator Sequencer

This block tracks the electrical angle of a two-phase stepper motor and turns it into digital current commands. The angle is held as a 6-bit index, 64 positions per electrical turn, so one index count is one sixteenth step. Each rising edge on the asynchronous step input moves the index by 8, 4, 2 or 1 counts in the chosen direction. The index is decoded into a signed magnitude code for phase A (sine of the angle) and for phase B (cosine of the angle). A monitor flag marks the diagonal positions, and an enable tells the downstream power stage whether it may drive.

A home request forces the index to the 45° home position and disables the outputs. Step edges are ignored during a home request. A sleep input drops the enable but keeps the sequencer live, so a controller can place the start position before it wakes the drive. A small controller with three states sets the operating mode. `ST_HOME` is entered through `T_ENTER_HOME` from any state while the home request or reset is active. `ST_RUN` is entered through `T_RELEASE_RUN` from home, or through `T_WAKE` from sleep. `ST_SLEEP` is entered through `T_RELEASE_SLEEP` from home, or through `T_DOZE` from run.

Top module: `stepseq_top`

## Requirements
- R1: The resolution select `res_sel` sets the step size in index counts: 2'b11 half step = 8, 2'b10 quarter step = 4, 2'b01 eighth step = 2, 2'b00 sixteenth step = 1.
- R2: Each low-to-high transition of `step_in` moves the index exactly once. With `dir_cw` = 1 the index rises, with 0 it falls, and it wraps modulo 64 in both directions.
- R3: Changing `res_sel` or `dir_cw` without a step edge leaves every output unchanged. The values in force are the ones present when the step edge is taken.
- R4: While `home_req` is high, or `rst_n` is low, the index is forced to 8 (45°), `drv_en` is low and step edges are ignored.
- R5: At the home index both magnitudes are 180 and both sign bits are 0.
- R6: `mon` is high exactly when the controller is not in `ST_HOME` and the index is 8, 24, 40 or 56. It is low during home.
- R7: While `step_in` stays at one level, high or low, the index does not change.
- R8: While `sleep` is high, `drv_en` is low, but step edges still move the index. `drv_en` is high only in `ST_RUN`.
- R9: For index i, `pha_mag` is round(255·|sin(2πi/64)|) and `phb_mag` is round(255·|cos(2πi/64)|). A sign bit is 1 when its value is negative and its magnitude is nonzero.
- R10: A step taken from an index that is not a multiple of the step size still adds the full increment. The index is not snapped to the coarser grid.
- R11: A `step_in` rise set up before clock edge 1 changes the outputs after edge 3, and not after edges 1 or 2. A change on `home_req` or `sleep` takes effect on `drv_en` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, acts as a home request |
| home_req | input | 1 | Synchronous home request, active high |
| step_in | input | 1 | Asynchronous step clock; a rising edge steps the index |
| res_sel | input | 2 | Step resolution select |
| dir_cw | input | 1 | Direction: 1 increases the index, 0 decreases it |
| sleep | input | 1 | Sleep: removes the drive enable, stepping stays live |
| pha_mag | output | 8 | Phase A current magnitude code |
| pha_neg | output | 1 | Phase A sign, 1 = negative |
| phb_mag | output | 8 | Phase B current magnitude code |
| phb_neg | output | 1 | Phase B sign, 1 = negative |
| mon | output | 1 | Diagonal-position monitor flag |
| drv_en | output | 1 | Power stage enable |

## Verification
A step passes through two synchroniser flops and one edge-detect flop, so its effect on the phase codes and `mon` is due after the third rising clock edge that follows the `step_in` rise. The phase codes and `mon` are decoded directly from the index with no further register. The bench drives every input on a falling edge. It holds each step level for four clocks and samples on falling edges only, after all three stages have settled. One dedicated test samples after edges 1, 2 and 3 to pin down that latency. `home_req` and `sleep` reach `drv_en` one edge later, and the bench waits at least that long before it checks the enable.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
    localparam int POS_W    = 6;
    localparam int MAG_W    = 8;
    localparam int QTR      = 2 ** (POS_W - 2);
    localparam int HOME_POS = QTR / 2;
    localparam int K_W      = POS_W - 1;

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [MAG_W-1:0] mag_t;

    typedef enum logic [1:0] {
        ST_HOME  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/step_sync.sv
module step_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            for (int k = STAGES - 1; k > 0; k--) begin
                sync_q[k] <= sync_q[k-1];
            end
            sync_q[0] <= async_in;
            last_q    <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

    // R2: a detected edge is a single-cycle pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import stepseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        home_req,
    input  logic        sleep,
    output ctrl_state_t state,
    output logic        step_ok,
    output logic        drv_en,
    output logic        in_home
);
    ctrl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOME: begin
                if (home_req)   state_d = ST_HOME;   // T_ENTER_HOME (hold)
                else if (sleep) state_d = ST_SLEEP;  // T_RELEASE_SLEEP
                else            state_d = ST_RUN;    // T_RELEASE_RUN
            end
            ST_RUN: begin
                if (home_req)   state_d = ST_HOME;   // T_ENTER_HOME
                else if (sleep) state_d = ST_SLEEP;  // T_DOZE
            end
            ST_SLEEP: begin
                if (home_req)   state_d = ST_HOME;   // T_ENTER_HOME
                else if (!sleep) state_d = ST_RUN;   // T_WAKE
            end
            default: state_d = ST_HOME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOME;
        else        state_q <= state_d;
    end

    always_comb begin
        state   = state_q;
        drv_en  = (state_q == ST_RUN);
        in_home = (state_q == ST_HOME);
        step_ok = (state_q != ST_HOME) && !home_req;
    end

    // R8: the enable only follows a cycle with neither sleep nor home request
    p_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(!sleep && !home_req));

    // R4: a home request always lands the controller in home
    p_home_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        home_req |=> in_home && !drv_en);
endmodule

// File: rtl/pos_track.sv
module pos_track
    import stepseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       home_req,
    input  logic       step_rise,
    input  logic       step_ok,
    input  logic [1:0] res_sel,
    input  logic       dir_cw,
    output pos_t       pos_q
);
    pos_t inc;

    assign inc = pos_t'(1) << res_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pos_q <= pos_t'(HOME_POS);
        else if (home_req)              pos_q <= pos_t'(HOME_POS);
        else if (step_rise && step_ok)  pos_q <= dir_cw ? pos_q + inc : pos_q - inc;
    end

    // R4: home request lands on the 45 degree index
    p_home_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        home_req |=> pos_q == pos_t'(HOME_POS));

    // R7: no accepted edge, no movement
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_rise && !home_req) |=> $stable(pos_q));

    // R1: an accepted step moves by a single power of two either way
    p_step_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rise && step_ok) |=>
            ($countones(pos_t'(pos_q - $past(pos_q))) == 1) ||
            ($countones(pos_t'($past(pos_q) - pos_q)) == 1));
endmodule

// File: rtl/wave_lut.sv
module wave_lut
    import stepseq_pkg::*;
(
    input  pos_t angle,
    output mag_t mag,
    output logic neg
);
    logic [1:0]     quad;
    logic [K_W-1:0] frac;
    logic [K_W-1:0] k;

    function automatic mag_t qsine(input logic [K_W-1:0] idx);
        unique case (idx)
            5'd0:  qsine = 8'd0;
            5'd1:  qsine = 8'd25;
            5'd2:  qsine = 8'd50;
            5'd3:  qsine = 8'd74;
            5'd4:  qsine = 8'd98;
            5'd5:  qsine = 8'd120;
            5'd6:  qsine = 8'd142;
            5'd7:  qsine = 8'd162;
            5'd8:  qsine = 8'd180;
            5'd9:  qsine = 8'd197;
            5'd10: qsine = 8'd212;
            5'd11: qsine = 8'd225;
            5'd12: qsine = 8'd236;
            5'd13: qsine = 8'd244;
            5'd14: qsine = 8'd250;
            5'd15: qsine = 8'd254;
            5'd16: qsine = 8'd255;
            default: qsine = 8'd0;
        endcase
    endfunction

    always_comb begin
        quad = angle[POS_W-1:POS_W-2];
        frac = {1'b0, angle[POS_W-3:0]};
        k    = quad[0] ? (K_W'(QTR) - frac) : frac;
        mag  = qsine(k);
        neg  = quad[1] && (mag != '0);
    end
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
    import stepseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       home_req,
    input  logic       step_in,
    input  logic [1:0] res_sel,
    input  logic       dir_cw,
    input  logic       sleep,
    output logic [7:0] pha_mag,
    output logic       pha_neg,
    output logic [7:0] phb_mag,
    output logic       phb_neg,
    output logic       mon,
    output logic       drv_en
);
    logic        step_rise;
    logic        step_ok;
    logic        in_home;
    ctrl_state_t state;
    pos_t        pos_q;
    mag_t        mag_w [2];
    logic        neg_w [2];

    step_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(step_in), .rise(step_rise)
    );

    seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .home_req(home_req), .sleep(sleep),
        .state(state), .step_ok(step_ok), .drv_en(drv_en), .in_home(in_home)
    );

    pos_track u_pos (
        .clk(clk), .rst_n(rst_n), .home_req(home_req), .step_rise(step_rise),
        .step_ok(step_ok), .res_sel(res_sel), .dir_cw(dir_cw), .pos_q(pos_q)
    );

    for (genvar p = 0; p < 2; p++) begin : g_phase
        pos_t ang;
        assign ang = pos_q + pos_t'(p * QTR);
        wave_lut u_lut (.angle(ang), .mag(mag_w[p]), .neg(neg_w[p]));
    end

    assign pha_mag = mag_w[0];
    assign pha_neg = neg_w[0];
    assign phb_mag = mag_w[1];
    assign phb_neg = neg_w[1];
    assign mon     = !in_home && (pos_q[POS_W-3:0] == (POS_W-2)'(HOME_POS));

    // R6: on a diagonal both phase magnitudes match
    p_mon_diag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mon |-> (pha_mag == phb_mag) && (state != ST_HOME));

    // R5: after a home request both phases sit positive at equal level
    p_home_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        home_req |=> !mon && !pha_neg && !phb_neg && (pha_mag == phb_mag));
endmodule

// File: tb/sim_stepseq_top.sv
module sim_stepseq_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n, home_req, step_in, dir_cw, sleep;
    logic [1:0] res_sel;
    logic [7:0] pha_mag, phb_mag;
    logic       pha_neg, phb_neg, mon, drv_en;

    int n_chk = 0;
    int n_bad = 0;
    int e_pos = 8;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    stepseq_top u0 (
        .clk(clk), .rst_n(rst_n), .home_req(home_req), .step_in(step_in),
        .res_sel(res_sel), .dir_cw(dir_cw), .sleep(sleep),
        .pha_mag(pha_mag), .pha_neg(pha_neg), .phb_mag(phb_mag),
        .phb_neg(phb_neg), .mon(mon), .drv_en(drv_en)
    );

    task automatic exp_code(input int i, input bit cosine, output int m, output bit n);
        real th, s;
        th = 2.0 * 3.14159265358979 * real'(i + (cosine ? 16 : 0)) / 64.0;
        s  = $sin(th);
        m  = $rtoi(255.0 * (s < 0.0 ? -s : s) + 0.5);
        n  = (s < 0.0) && (m != 0);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_pos(input int e, input bit home, input string tag);
        int ma, mb; bit na, nb; bit em;
        exp_code(e, 1'b0, ma, na);
        exp_code(e, 1'b1, mb, nb);
        em = !home && ((e % 16) == 8);
        chk(pha_mag == ma[7:0] && pha_neg == na, {tag, " phaseA"}, {pha_neg, pha_mag}, {na, ma[7:0]});
        chk(phb_mag == mb[7:0] && phb_neg == nb, {tag, " phaseB"}, {phb_neg, phb_mag}, {nb, mb[7:0]});
        chk(mon == em, {tag, " R6 mon"}, mon, em);
    endtask

    task automatic do_step(input logic [1:0] rs, input bit cw, input bit model);
        int d;
        res_sel = rs; dir_cw = cw;
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        if (model) begin
            d = 1 << rs;
            e_pos = (((e_pos + (cw ? d : -d)) % 64) + 64) % 64;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; home_req = 1'b0; step_in = 1'b0;
        res_sel = 2'b00; dir_cw = 1'b1; sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state, still in home: R4 R5
        check_pos(8, 1'b1, "R4 R5 reset");
        chk(drv_en == 1'b0, "R4 reset drv_en", drv_en, 0);
        chk(pha_mag == 8'd180 && phb_mag == 8'd180, "R5 home level", pha_mag, 180);
        repeat (2) @(negedge clk);
        chk(drv_en == 1'b1, "R8 run enable", drv_en, 1);
        check_pos(8, 1'b0, "R6 home mon after release");

        // R11 latency of one sixteenth step CW
        res_sel = 2'b00; dir_cw = 1'b1; step_in = 1'b1;
        @(negedge clk); check_pos(8, 1'b0, "R11 edge1");
        @(negedge clk); check_pos(8, 1'b0, "R11 edge2");
        @(negedge clk); check_pos(9, 1'b0, "R11 edge3");
        // R7: hold high
        repeat (10) @(negedge clk); check_pos(9, 1'b0, "R7 held high");
        step_in = 1'b0;
        repeat (10) @(negedge clk); check_pos(9, 1'b0, "R7 held low");
        e_pos = 9;

        // R9 R2: full sweep at sixteenth step CW
        for (int k = 0; k < 64; k++) begin
            do_step(2'b00, 1'b1, 1'b1);
            check_pos(e_pos, 1'b0, "R9 R2 sweep");
        end

        // R1 R10: half step from off-grid index 9
        do_step(2'b11, 1'b1, 1'b1);
        check_pos(e_pos, 1'b0, "R1 R10 half off-grid");
        chk(e_pos == 17, "R10 model", e_pos, 17);
        // R2 wrap CCW with eighth steps, quarter steps CCW
        for (int k = 0; k < 12; k++) begin
            do_step(2'b01, 1'b0, 1'b1);
            check_pos(e_pos, 1'b0, "R1 R2 eighth CCW");
        end
        for (int k = 0; k < 20; k++) begin
            do_step(2'b10, 1'b0, 1'b1);
            check_pos(e_pos, 1'b0, "R1 R2 quarter CCW wrap");
        end
        for (int k = 0; k < 9; k++) begin
            do_step(2'b11, 1'b1, 1'b1);
            check_pos(e_pos, 1'b0, "R1 R2 half CW wrap");
        end

        // R3: change select and direction without a step
        res_sel = 2'b11; dir_cw = 1'b0;
        repeat (6) @(negedge clk);
        res_sel = 2'b01; dir_cw = 1'b1;
        repeat (6) @(negedge clk);
        check_pos(e_pos, 1'b0, "R3 no step no move");

        // R4: home request with steps ignored
        home_req = 1'b1;
        @(negedge clk);
        chk(drv_en == 1'b0, "R4 home drv_en", drv_en, 0);
        for (int k = 0; k < 3; k++) do_step(2'b11, 1'b1, 1'b0);
        e_pos = 8;
        check_pos(8, 1'b1, "R4 R5 home hold");
        chk(drv_en == 1'b0, "R4 drv_en during home", drv_en, 0);
        home_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(drv_en == 1'b1, "R8 enable after home", drv_en, 1);

        // R8: sleep keeps stepping
        sleep = 1'b1;
        @(negedge clk);
        chk(drv_en == 1'b0, "R8 sleep drv_en", drv_en, 0);
        do_step(2'b11, 1'b1, 1'b1);
        check_pos(e_pos, 1'b0, "R8 step in sleep");
        do_step(2'b00, 1'b0, 1'b1);
        check_pos(e_pos, 1'b0, "R8 R10 off-grid in sleep");
        chk(drv_en == 1'b0, "R8 still asleep", drv_en, 0);
        sleep = 1'b0;
        @(negedge clk);
        chk(drv_en == 1'b1, "R8 wake", drv_en, 1);

        // R4: asynchronous reset also homes
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_pos(8, 1'b1, "R4 rst_n home");
        finish_run();
    end
endmodule